// File: doc/BRIEF.md
# Time-Slotted Bus Arbiter with Round-Robin Fallback

This block decides which of `N_REQ` bus masters may use a shared bus. Time is cut into slots of `SLOT_CYC` clock cycles, and `SLOTS` consecutive slots form a repeating frame. A small configuration table holds one entry per slot. An entry either reserves its slot for one master or leaves the slot open.

During a reserved slot, the reserving master wins whenever it asks for the bus. Any other master can win only if that master is not asking. Open slots, and reserved slots that their holder leaves unused, are shared out fairly through a rotating pointer.

A grant is held for as long as the winner keeps requesting. The grant becomes usable only after a programmable wait of 2 to 7 cycles, which `gnt_ready` reports. Software changes the table and the wait through a small write port. A change is staged, and it takes effect at the next frame boundary. Because of this, a frame in progress never mixes old and new settings.

Top module: `tdma_arb`

## Requirements
- R1: A synchronous active-high `rst` drives `gnt` and `gnt_ready` low in the cycle after it is sampled. It also sets the slot position to slot 0, cycle 0, and the rotating pointer to master 0. Every table entry becomes open, and the wait is set to 2 for both the staged and the live copies.
- R2: The slot position advances one slot every `SLOT_CYC` cycles and wraps to slot 0 after slot `SLOTS-1`. An arbitration decision uses the slot that is current in the cycle of the decision.
- R3: When the live entry of the current slot reserves the slot for master `k`, and `req[k]` is high, master `k` is granted. No other master is considered.
- R4: In an open slot, the winner is the first requesting master found when scanning upward from the rotating pointer, wrapping past `N_REQ-1` to 0.
- R5: In a reserved slot whose holder is not requesting, the winner is chosen among the other requesting masters, by the same scan as in R4.
- R6: After a grant made by the scan, the pointer moves to one past the winner, wrapping to 0. A grant to a slot holder leaves the pointer unchanged. A cycle with no request neither grants nor moves the pointer.
- R7: `gnt` is one-hot or zero, and it only goes to a master whose request was high in the cycle of the decision. It stays unchanged while that master holds `req` high. In the cycle after the master drops `req`, `gnt` goes to zero. The next decision is made one cycle later.
- R8: `gnt_ready` rises exactly L cycles after `gnt` rises, where L is the live wait. It stays high with the grant and falls with it.
- R9: A write with `cfg_we` high stages a value, and the value goes live at the frame boundary (the last cycle of slot `SLOTS-1`). A decision made in that boundary cycle still uses the old values. Address `a < SLOTS` stages the entry for slot `a`: `cfg_wdata[7]` = 1 reserves the slot for master `cfg_wdata[6:0]`, and an owner number at or above `N_REQ` leaves the slot open. Address `SLOTS` stages the wait from `cfg_wdata[3:0]`. A write to any higher address changes nothing.
- R10: A staged wait below 2 becomes 2, and a staged wait above 7 becomes 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_REQ | One request line per master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | clog2(SLOTS)+1 | Slot entry index, or `SLOTS` for the wait setting |
| cfg_wdata | input | 8 | Entry value (bit 7 = reserved, bits 6:0 = owner) or wait value (bits 3:0) |
| gnt | output | N_REQ | One-hot grant |
| gnt_ready | output | 1 | Grant is usable; the wait has elapsed |

## Verification
Two functions can land in the same cycle: the switch to new settings at the frame boundary, and an arbitration decision. The bench stages a new wait while an older one is live. It then raises a request so that the decision falls exactly on the last cycle of the frame. That grant must still follow the old slot owner and the old wait. The next grant, in the new frame, must show the new wait.

// File: rtl/tdma_arb.sv
module tdma_arb #(
  parameter int N_REQ    = 4,
  parameter int SLOTS    = 8,
  parameter int SLOT_CYC = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_REQ-1:0]              req,
  input  logic                          cfg_we,
  input  logic [$clog2(SLOTS > 1 ? SLOTS : 2):0] cfg_addr,
  input  logic [7:0]                    cfg_wdata,
  output logic [N_REQ-1:0]              gnt,
  output logic                          gnt_ready
);
  localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam int SW  = $clog2(SLOTS > 1 ? SLOTS : 2);
  localparam int AW  = SW + 1;
  localparam int TW  = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [TW-1:0]  LAST_TICK = TW'(SLOT_CYC - 1);
  localparam logic [SW-1:0]  LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [IDW-1:0] LAST_ID   = IDW'(N_REQ - 1);

  function automatic logic [2:0] clamp_wait(input logic [3:0] v);
    if (v < 4'd2) return 3'd2;
    if (v > 4'd7) return 3'd7;
    return v[2:0];
  endfunction

  logic [TW-1:0]    tick;
  logic [SW-1:0]    slot;
  logic [SLOTS-1:0] own_stage, own_live;
  logic [IDW-1:0]   id_stage [SLOTS];
  logic [IDW-1:0]   id_live  [SLOTS];
  logic [2:0]       wait_stage, wait_live, wait_cnt;
  logic [IDW-1:0]   rr_ptr, rr_win;
  logic             rr_hit;

  wire slot_end  = (tick == LAST_TICK);
  wire frame_end = slot_end && (slot == LAST_SLOT);
  wire busy      = |gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      slot <= '0;
    end else if (slot_end) begin
      tick <= '0;
      slot <= frame_end ? '0 : slot + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        own_stage[i] <= 1'b0;
        id_stage[i]  <= '0;
        own_live[i]  <= 1'b0;
        id_live[i]   <= '0;
      end else begin
        if (cfg_we && cfg_addr == AW'(i)) begin
          own_stage[i] <= cfg_wdata[7] && (32'(cfg_wdata[6:0]) < N_REQ);
          id_stage[i]  <= cfg_wdata[IDW-1:0];
        end
        if (frame_end) begin
          own_live[i] <= own_stage[i];
          id_live[i]  <= id_stage[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_stage <= 3'd2;
      wait_live  <= 3'd2;
    end else begin
      if (cfg_we && cfg_addr == AW'(SLOTS))
        wait_stage <= clamp_wait(cfg_wdata[3:0]);
      if (frame_end)
        wait_live <= wait_stage;
    end
  end

  wire [IDW-1:0] cur_id   = id_live[slot];
  wire           owner_ok = own_live[slot] && req[cur_id];

  always_comb begin
    rr_hit = 1'b0;
    rr_win = '0;
    for (int k = 0; k < N_REQ; k++) begin
      if (!rr_hit && req[(int'(rr_ptr) + k) % N_REQ]) begin
        rr_hit = 1'b1;
        rr_win = IDW'((int'(rr_ptr) + k) % N_REQ);
      end
    end
  end

  wire [IDW-1:0] win_id  = owner_ok ? cur_id : rr_win;
  wire [IDW-1:0] rr_next = (rr_win == LAST_ID) ? '0 : rr_win + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt       <= '0;
      gnt_ready <= 1'b0;
      wait_cnt  <= '0;
      rr_ptr    <= '0;
    end else if (!busy) begin
      if (rr_hit) begin
        gnt       <= N_REQ'(1) << win_id;
        gnt_ready <= 1'b0;
        wait_cnt  <= wait_live;
        if (!owner_ok) rr_ptr <= rr_next;
      end
    end else if (!(|(gnt & req))) begin
      gnt       <= '0;
      gnt_ready <= 1'b0;
    end else if (!gnt_ready) begin
      wait_cnt  <= wait_cnt - 3'd1;
      gnt_ready <= (wait_cnt == 3'd1);
    end
  end
endmodule

// File: rtl/tdma_arb_chk.sv
module tdma_arb_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req,
  input logic [N_REQ-1:0] gnt,
  input logic             gnt_ready
);
  assert_gnt_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_gnt_to_requester_R7: assert property (@(posedge clk) disable iff (rst)
    (|gnt && !$past(|gnt)) |-> |(gnt & $past(req)));

  assert_gnt_held_R7: assert property (@(posedge clk) disable iff (rst)
    (|(gnt & req)) |=> (gnt == $past(gnt)));

  assert_gnt_release_R7: assert property (@(posedge clk) disable iff (rst)
    (|gnt && !(|(gnt & req))) |=> (gnt == '0));

  assert_no_req_no_gnt_R6: assert property (@(posedge clk) disable iff (rst)
    (req == '0 && gnt == '0) |=> (gnt == '0));

  assert_ready_needs_gnt_R8: assert property (@(posedge clk) disable iff (rst)
    gnt_ready |-> |gnt);

  assert_ready_min_wait_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_ready) |-> ($past(gnt, 1) == gnt && $past(gnt, 2) == gnt));
endmodule

bind tdma_arb tdma_arb_chk #(.N_REQ(N_REQ)) u_chk (
  .clk(clk), .rst(rst), .req(req), .gnt(gnt), .gnt_ready(gnt_ready)
);

// File: tb/tdma_arb_test.sv
module tdma_arb_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N  = 4;
  localparam int SL = 4;
  localparam int SC = 16;
  localparam int FR = SL * SC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] gnt;
  logic       gnt_ready;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  tdma_arb #(.N_REQ(N), .SLOTS(SL), .SLOT_CYC(SC)) uut (
    .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gnt(gnt), .gnt_ready(gnt_ready)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // {slot[1:0], req[3:0], expected grant[3:0]}, run with wait 3
  localparam logic [9:0] VEC [10] = '{
    {2'd0, 4'b0101, 4'b0100},
    {2'd0, 4'b0011, 4'b0010},
    {2'd1, 4'b1110, 4'b0010},
    {2'd2, 4'b1011, 4'b1000},
    {2'd2, 4'b1011, 4'b0001},
    {2'd3, 4'b0111, 4'b0010},
    {2'd3, 4'b1001, 4'b1000},
    {2'd1, 4'b0101, 4'b0100},
    {2'd2, 4'b0001, 4'b0001},
    {2'd0, 4'b1111, 4'b0100}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_pos(input int pos);
    do @(negedge clk); while (cyc % FR != pos);
  endtask

  task automatic run_grant(input int pos, input logic [3:0] r, input logic [3:0] eg,
                           input int lat, input string tag);
    bit early;
    early = 1'b0;
    wait_pos(pos);
    req = r;
    @(negedge clk);
    check(gnt == eg, {tag, " grant"}, 32'(gnt), 32'(eg));
    for (int j = 1; j <= lat; j++) begin
      @(negedge clk);
      if (j < lat && gnt_ready) early = 1'b1;
    end
    check(gnt_ready && !early && gnt == eg, {tag, " R8 wait"},
          {early, 27'd0, gnt_ready}, 32'd1);
    req = '0;
    @(negedge clk);
    check(gnt == '0 && !gnt_ready, {tag, " R7 release"}, 32'(gnt), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(gnt == '0 && gnt_ready == 1'b0, "R1 reset outputs", {gnt_ready, gnt}, 32'd0);
    rst = 1'b0;

    cfg_write(3'd0, 8'h82);
    cfg_write(3'd1, 8'h81);
    cfg_write(3'd2, 8'h00);
    cfg_write(3'd3, 8'h83);
    cfg_write(3'd4, 8'h03);

    // still frame 0: entries staged only, slot 1 is open, wait 2 (R9)
    run_grant(1 * SC + 2, 4'b0011, 4'b0001, 2, "R9 staged not live R4");

    // slot boundary: last cycle of slot 0 vs first cycle of slot 1 (R2)
    run_grant(SC - 1, 4'b0110, 4'b0100, 3, "R2 last cycle slot0");
    run_grant(SC, 4'b0110, 4'b0010, 3, "R2 first cycle slot1");

    for (int v = 0; v < 10; v++) begin
      run_grant(int'(VEC[v][9:8]) * SC + 2, VEC[v][7:4], VEC[v][3:0], 3,
                $sformatf("vector %0d R3 R4 R5 R6", v));
    end

    // idle cycles leave the pointer alone (R6)
    wait_pos(2 * SC + 1);
    repeat (6) @(negedge clk);
    check(gnt == '0, "R6 idle no grant", 32'(gnt), 32'd0);
    run_grant(2 * SC + 2, 4'b1111, 4'b0010, 3, "R6 pointer unmoved by idle");

    // hold and hand-over (R7)
    wait_pos(2 * SC + 2);
    req = 4'b0011;
    @(negedge clk);
    check(gnt == 4'b0001, "R7 hold grant", 32'(gnt), 32'h1);
    begin
      bit moved;
      moved = 1'b0;
      repeat (9) begin
        @(negedge clk);
        if (gnt != 4'b0001) moved = 1'b1;
      end
      check(!moved, "R7 grant stable while requested", 32'(moved), 32'd0);
    end
    req = 4'b0010;
    @(negedge clk);
    check(gnt == '0, "R7 gap after release", 32'(gnt), 32'd0);
    @(negedge clk);
    check(gnt == 4'b0010, "R7 next master granted", 32'(gnt), 32'h2);
    req = '0;
    @(negedge clk);

    // switch-over and decision in the same cycle (R9)
    cfg_write(3'd4, 8'h05);
    run_grant(FR - 1, 4'b1000, 4'b1000, 3, "R9 boundary uses old");
    run_grant(2, 4'b0100, 4'b0100, 5, "R9 new wait live");

    // clamping (R10)
    cfg_write(3'd4, 8'h00);
    wait_pos(1);
    run_grant(2 * SC + 2, 4'b0001, 4'b0001, 2, "R10 low clamp");
    cfg_write(3'd4, 8'h0C);
    cfg_write(3'd5, 8'h00);
    wait_pos(1);
    run_grant(1 * SC + 2, 4'b0011, 4'b0010, 7, "R10 high clamp R9 bad addr");

    // reset while a grant is held (R1)
    wait_pos(2 * SC + 2);
    req = 4'b0001;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(gnt == '0 && !gnt_ready, "R1 reset mid grant", {gnt_ready, gnt}, 32'd0);
    req = '0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R7 actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule